// File: doc/BRIEF.md
# Delayed-Write Cartridge Bank Mapper

This block sits behind a 4 KB processor address window. It presents that window as two 2 KB slots, lower and upper. Each slot is backed by one of four 2 KB banks: three RAM banks and one ROM bank. The processor bus can only read the cartridge, so a store is carried through the address lines instead. An access to the low page of the window (address bits 11:8 all zero) captures address bits 7:0 as a data byte. The fifth bus access after that capture writes the byte into whichever bank backs the slot that this fifth access targets. A dedicated trigger address copies the captured byte into the configuration register. That register picks the slot mapping and the write enable, and it switches the ROM supply.

The write path is a two-state machine. In `WS_IDLE` no byte is waiting. In `WS_ARMED` a captured byte is waiting and a saturating access counter runs. The transitions are CAPTURE (`WS_IDLE`→`WS_ARMED`, and `WS_ARMED`→`WS_ARMED` when a fresh byte is captured), COMMIT (`WS_ARMED`→`WS_IDLE` on the fifth access with writes on), RECONFIG (`WS_ARMED`→`WS_IDLE` on the trigger address) and EXPIRE (`WS_ARMED`→`WS_IDLE` once more than five accesses have gone by). Read data is registered. It appears the cycle after an access strobe and holds until the next strobe.

Top module: `cart_dwrite_mapper`

## Requirements
- R1: After reset the configuration byte is 0x00: the lower slot maps RAM bank 2, the upper slot maps ROM, writes are disabled, `rom_pwr_on` is 1, the captured byte is 0x00, no write is pending, and `rd_data` shows the ROM fill byte (default 0xFF).
- R2: A strobed access with address bits 11:8 all zero captures address bits 7:0 and arms a write, but only while writes are disabled or no live write is pending. With writes disabled, a later low-page access replaces the captured byte.
- R3: A strobed access to window offset 0xFF8 disarms any pending write and loads the captured byte as the new configuration. A write armed before it is never committed.
- R4: With writes enabled, the captured byte is written on exactly the fifth strobed access after the capture, and on no earlier access. Address bit 11 of that access selects the slot (0 lower, 1 upper) and bits 10:0 select the byte within the bank.
- R5: A commit aimed at a slot that maps ROM changes no RAM byte, but it still disarms the pending write.
- R6: A pending write never outlives the fifth access after its capture. Once it has committed, been dropped or expired, the next low-page access captures a new byte even with writes enabled.
- R7: In the configuration byte, bit 0 = 0 turns the ROM supply on (`rom_pwr_on`=1), bit 1 = 1 enables writes, bits 4:2 are the mapping code, and bits 7:5 have no effect.
- R8: Mapping codes 0..7 give (lower, upper) banks (2,ROM), (0,ROM), (2,0), (0,2), (2,ROM), (1,ROM), (2,1), (1,2). A ROM slot reads the fill byte.
- R9: Decode priority is expire check, then capture, then trigger address, then commit. While writes are enabled and a write is live, a low-page access does not recapture. When the fifth access is the trigger address, it reconfigures and does not write.
- R10: `rd_data` is the byte at the slot offset in the bank the slot maps after the access. It is valid from the cycle after the strobe, it holds until the next strobe, and on a commit access it shows the newly written byte.
- R11: Cycles without `acc_stb` neither advance the access count nor change any state or `rd_data`, whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | One bus access per cycle in which it is high |
| acc_addr | input | 12 | Offset of the access within the 4 KB window |
| rd_data | output | 8 | Byte read by the latest access |
| rom_pwr_on | output | 1 | ROM supply enable from configuration bit 0 |

## Verification
An access counter that is off by one shows up as a byte landing one access early or late. The bench sees this on the commit access itself, because that access reads back the slot it targets. A pending flag stuck armed blocks the next capture. Within five accesses, a second write then fails to appear, or a stale byte lands after a reconfiguration. A wrong slot-map entry or a wrong configuration bit is visible on the first read through the affected slot after the trigger access, since every RAM bank is pre-marked with a distinct byte.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

    typedef enum logic [1:0] {
        BK_RAM0 = 2'd0,
        BK_RAM1 = 2'd1,
        BK_RAM2 = 2'd2,
        BK_ROM  = 2'd3
    } bank_id_t;

    typedef enum logic {
        WS_IDLE  = 1'b0,
        WS_ARMED = 1'b1
    } wr_state_t;

    // bit positions are decoded by the slot map and the top
    typedef struct packed {
        logic [2:0] pulse;    // 7:5, no effect
        logic [2:0] mode;     // 4:2, slot mapping
        logic       wr_on;    // 1, write enable
        logic       rom_off;  // 0, ROM supply off when set
    } cfg_t;

endpackage

// File: rtl/cart_slot_map.sv
module cart_slot_map
    import cart_map_pkg::*;
(
    input  logic [2:0] mode,
    output bank_id_t   lo_bank,
    output bank_id_t   hi_bank
);

    always_comb begin
        unique case (mode)
            3'd0: begin lo_bank = BK_RAM2; hi_bank = BK_ROM;  end
            3'd1: begin lo_bank = BK_RAM0; hi_bank = BK_ROM;  end
            3'd2: begin lo_bank = BK_RAM2; hi_bank = BK_RAM0; end
            3'd3: begin lo_bank = BK_RAM0; hi_bank = BK_RAM2; end
            3'd4: begin lo_bank = BK_RAM2; hi_bank = BK_ROM;  end
            3'd5: begin lo_bank = BK_RAM1; hi_bank = BK_ROM;  end
            3'd6: begin lo_bank = BK_RAM2; hi_bank = BK_RAM1; end
            default: begin lo_bank = BK_RAM1; hi_bank = BK_RAM2; end
        endcase
    end

endmodule

// File: rtl/cart_hold_fsm.sv
module cart_hold_fsm
    import cart_map_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          WR_DELAY = 5,
    parameter logic [11:0] HOT_ADDR = 12'hFF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_stb,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              wr_enabled,
    output logic [7:0]        hold_byte,
    output logic              do_latch,
    output logic              do_cfg,
    output logic              do_commit
);

    localparam int CNT_MAX = WR_DELAY + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    wr_state_t         state_q, state_d;
    logic [CNT_W-1:0]  delta_q, delta_d, delta_inc;
    logic [7:0]        hold_q, hold_d;
    logic              live, low_page, hot;

    // saturating distance since capture; never wraps into a false match
    assign delta_inc = (delta_q == CNT_W'(CNT_MAX)) ? delta_q : delta_q + 1'b1;
    assign live      = (state_q == WS_ARMED) && (delta_inc <= CNT_W'(WR_DELAY));
    assign low_page  = (acc_addr[ADDR_W-1:8] == '0);
    assign hot       = (acc_addr == ADDR_W'(HOT_ADDR));
    assign hold_byte = hold_q;

    // output decode, priority: expire (via live), capture, trigger, commit
    always_comb begin
        do_latch  = acc_stb && low_page && (!wr_enabled || !live);
        do_cfg    = acc_stb && !do_latch && hot;
        do_commit = acc_stb && !do_latch && !hot && wr_enabled && live &&
                    (delta_inc == CNT_W'(WR_DELAY));
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: begin
                if (do_latch) state_d = WS_ARMED;               // CAPTURE
            end
            WS_ARMED: begin
                if (do_latch)                     state_d = WS_ARMED; // CAPTURE
                else if (do_cfg)                  state_d = WS_IDLE;  // RECONFIG
                else if (do_commit)               state_d = WS_IDLE;  // COMMIT
                else if (acc_stb && !live)        state_d = WS_IDLE;  // EXPIRE
            end
            default: state_d = WS_IDLE;
        endcase
        if (do_latch)     delta_d = '0;
        else if (acc_stb) delta_d = delta_inc;
        else              delta_d = delta_q;
        hold_d = do_latch ? acc_addr[7:0] : hold_q;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            delta_q <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            delta_q <= delta_d;
            hold_q  <= hold_d;
        end
    end

    p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        do_latch |=> (state_q == WS_ARMED) && (hold_q == $past(acc_addr[7:0])));

    p_cfg_disarms_r3: assert property (@(posedge clk) disable iff (!rst_n)
        do_cfg |=> (state_q == WS_IDLE));

    p_commit_disarms_r4: assert property (@(posedge clk) disable iff (!rst_n)
        do_commit |=> (state_q == WS_IDLE));

    p_armed_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_ARMED) |-> (delta_q <= CNT_W'(WR_DELAY)));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_stb |=> $stable(hold_q) && $stable(state_q));

endmodule

// File: rtl/cart_bank_store.sv
module cart_bank_store
    import cart_map_pkg::*;
#(
    parameter int         BANK_AW   = 11,
    parameter int         RAM_BANKS = 3,
    parameter logic [7:0] ROM_FILL  = 8'hFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  bank_id_t           wr_bank,
    input  logic [BANK_AW-1:0] wr_off,
    input  logic [7:0]         wr_data,
    input  logic               rd_stb,
    input  bank_id_t           rd_bank,
    input  logic [BANK_AW-1:0] rd_off,
    output logic [7:0]         rd_data
);

    localparam int BANK_BYTES = 1 << BANK_AW;

    bank_id_t           rbank_q;
    logic [BANK_AW-1:0] roff_q;
    logic [7:0]         bank_rd [RAM_BANKS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbank_q <= BK_ROM;
            roff_q  <= '0;
        end else if (rd_stb) begin
            rbank_q <= rd_bank;
            roff_q  <= rd_off;
        end
    end

    for (genvar b = 0; b < RAM_BANKS; b++) begin : g_bank
        logic [7:0] mem [BANK_BYTES];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == bank_id_t'(b)))
                mem[wr_off] <= wr_data;
        end
        assign bank_rd[b] = mem[roff_q];
    end

    // read after write: the committed byte is in the array by the time it is read
    always_comb begin
        rd_data = ROM_FILL;
        for (int b = 0; b < RAM_BANKS; b++) begin
            if (rbank_q == bank_id_t'(b)) rd_data = bank_rd[b];
        end
    end

    p_rom_unwritten_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_bank != BK_ROM));

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

endmodule

// File: rtl/cart_dwrite_mapper.sv
module cart_dwrite_mapper
    import cart_map_pkg::*;
#(
    parameter int          BANK_AW   = 11,
    parameter int          WR_DELAY  = 5,
    parameter logic [11:0] HOT_ADDR  = 12'hFF8,
    parameter logic [7:0]  ROM_FILL  = 8'hFF,
    localparam int         ADDR_W    = BANK_AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_stb,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [7:0]        rd_data,
    output logic              rom_pwr_on
);

    localparam int RAM_BANKS = 3;

    cfg_t               cfg_q, cfg_d;
    logic [7:0]         hold_byte;
    logic               do_latch, do_cfg, do_commit;
    bank_id_t           cur_lo, cur_hi, nxt_lo, nxt_hi;
    bank_id_t           tgt_bank, rd_bank;
    logic               upper_slot, wr_en;
    logic [BANK_AW-1:0] slot_off;

    cart_hold_fsm #(
        .ADDR_W   (ADDR_W),
        .WR_DELAY (WR_DELAY),
        .HOT_ADDR (HOT_ADDR)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_stb    (acc_stb),
        .acc_addr   (acc_addr),
        .wr_enabled (cfg_q.wr_on),
        .hold_byte  (hold_byte),
        .do_latch   (do_latch),
        .do_cfg     (do_cfg),
        .do_commit  (do_commit)
    );

    assign cfg_d = do_cfg ? cfg_t'(hold_byte) : cfg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    cart_slot_map u_map_cur (.mode(cfg_q.mode), .lo_bank(cur_lo), .hi_bank(cur_hi));
    cart_slot_map u_map_nxt (.mode(cfg_d.mode), .lo_bank(nxt_lo), .hi_bank(nxt_hi));

    assign upper_slot = acc_addr[ADDR_W-1];
    assign slot_off   = acc_addr[BANK_AW-1:0];
    assign tgt_bank   = upper_slot ? cur_hi : cur_lo;
    assign rd_bank    = upper_slot ? nxt_hi : nxt_lo;
    assign wr_en      = do_commit && (tgt_bank != BK_ROM);
    assign rom_pwr_on = !cfg_q.rom_off;

    cart_bank_store #(
        .BANK_AW   (BANK_AW),
        .RAM_BANKS (RAM_BANKS),
        .ROM_FILL  (ROM_FILL)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bank (tgt_bank),
        .wr_off  (slot_off),
        .wr_data (hold_byte),
        .rd_stb  (acc_stb),
        .rd_bank (rd_bank),
        .rd_off  (slot_off),
        .rd_data (rd_data)
    );

    p_commit_needs_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        do_commit |-> cfg_q.wr_on);

    p_cfg_applied_r3: assert property (@(posedge clk) disable iff (!rst_n)
        do_cfg |=> (cfg_q == $past(hold_byte)));

    p_onehot_action_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_latch, do_cfg, do_commit}));

    p_cfg_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_stb |=> $stable(cfg_q));

endmodule

// File: tb/cart_dwrite_mapper_tb.sv
module cart_dwrite_mapper_tb;

    localparam logic [7:0]  FILL = 8'hFF;
    localparam logic [11:0] PAD  = 12'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_stb = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [7:0]  rd_data;
    logic        rom_pwr_on;
    logic [7:0]  last_rd;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    cart_dwrite_mapper u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_stb    (acc_stb),
        .acc_addr   (acc_addr),
        .rd_data    (rd_data),
        .rom_pwr_on (rom_pwr_on)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(input logic [11:0] a);
        @(negedge clk);
        acc_stb  = 1'b1;
        acc_addr = a;
        @(negedge clk);
        acc_stb  = 1'b0;
        last_rd  = rd_data;
    endtask

    task automatic set_cfg(input logic [7:0] b);
        access({4'h0, b});
        access(12'hFF8);
    endtask

    task automatic do_write(input logic [7:0] b, input logic [11:0] tgt);
        access({4'h0, b});
        for (int i = 0; i < 4; i++) access(PAD);
        access(tgt);
    endtask

    function automatic logic [1:0] exp_lo(input int c);
        case (c)
            1, 3: return 2'd0;
            5, 7: return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [1:0] exp_hi(input int c);
        case (c)
            2: return 2'd0;
            6: return 2'd1;
            3, 7: return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [7:0] marker(input logic [1:0] bk);
        case (bk)
            2'd0: return 8'hA0;
            2'd1: return 8'hB1;
            2'd2: return 8'hC2;
            default: return FILL;
        endcase
    endfunction

    task automatic t_reset;
        check(rd_data == FILL, "R1 rd_data", rd_data, FILL);
        check(rom_pwr_on == 1'b1, "R1 rom_pwr_on", rom_pwr_on, 1);
        access(12'h923);
        check(last_rd == FILL, "R1 upper is ROM", last_rd, FILL);
        access(12'hFF8);
        check(rom_pwr_on == 1'b1 && last_rd == FILL, "R1 hold cleared", last_rd, FILL);
    endtask

    task automatic t_mapping;
        set_cfg(8'h0E);
        do_write(8'hA0, 12'h123);
        check(last_rd == 8'hA0, "R10 commit read shows new byte", last_rd, 8'hA0);
        do_write(8'hC2, 12'h923);
        check(last_rd == 8'hC2, "R4 upper slot write", last_rd, 8'hC2);
        set_cfg(8'h1E);
        do_write(8'hB1, 12'h123);
        for (int c = 0; c < 8; c++) begin
            set_cfg(8'((c << 2) | 1));
            access(12'h123);
            check(last_rd == marker(exp_lo(c)), $sformatf("R8 code %0d lower", c),
                  last_rd, marker(exp_lo(c)));
            access(12'h923);
            check(last_rd == marker(exp_hi(c)), $sformatf("R8 code %0d upper", c),
                  last_rd, marker(exp_hi(c)));
        end
    endtask

    task automatic t_write_window;
        set_cfg(8'h0E);
        do_write(8'h22, 12'h155);
        access(12'h066);
        for (int i = 1; i <= 4; i++) begin
            access(12'h155);
            check(last_rd == 8'h22, $sformatf("R4 no write at access %0d", i), last_rd, 8'h22);
        end
        access(12'h155);
        check(last_rd == 8'h66, "R4 write at fifth access", last_rd, 8'h66);
    endtask

    task automatic t_relatch;
        do_write(8'h31, 12'h1A0);
        do_write(8'h32, 12'h1A0);
        check(last_rd == 8'h32, "R6 recapture after commit", last_rd, 8'h32);
    endtask

    task automatic t_rom_drop;
        set_cfg(8'h06);
        do_write(8'h99, 12'h923);
        check(last_rd == FILL, "R5 ROM slot reads fill", last_rd, FILL);
        do_write(8'h98, 12'h1AA);
        check(last_rd == 8'h98, "R5 pending cleared after drop", last_rd, 8'h98);
        set_cfg(8'h0E);
        access(12'h923);
        check(last_rd == 8'hC2, "R5 RAM untouched by drop", last_rd, 8'hC2);
    endtask

    task automatic t_priority;
        set_cfg(8'h0A);
        do_write(8'h5C, 12'h7F8);
        set_cfg(8'h0E);
        access(12'h01E);
        access(12'h0AA);
        for (int i = 0; i < 3; i++) access(PAD);
        access(12'hFF8);
        check(last_rd == 8'h5C, "R9 trigger wins over commit", last_rd, 8'h5C);
        access(12'h123);
        check(last_rd == 8'hB1, "R3 captured byte applied, no recapture R9", last_rd, 8'hB1);
    endtask

    task automatic t_cfg_disarm;
        set_cfg(8'h0E);
        do_write(8'h66, 12'h155);
        access(12'h00E);
        access(12'hFF8);
        for (int i = 0; i < 4; i++) access(12'h155);
        check(last_rd == 8'h66, "R3 trigger disarms pending write", last_rd, 8'h66);
    endtask

    task automatic t_nostrobe;
        logic [7:0] held;
        set_cfg(8'h0E);
        access(12'h071);
        held = rd_data;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            acc_addr = (i % 2 == 0) ? 12'hFF8 : 12'h0E1;
        end
        check(rd_data == held, "R11 rd_data held without strobe", rd_data, held);
        for (int i = 0; i < 4; i++) access(PAD);
        access(12'h1B0);
        check(last_rd == 8'h71, "R11 idle cycles not counted", last_rd, 8'h71);
    endtask

    task automatic t_we_off_recapture;
        set_cfg(8'h0D);
        access(12'h00F);
        access(12'h044);
        access(12'hFF8);
        access(12'h923);
        check(last_rd == FILL, "R2 newest capture applied", last_rd, FILL);
        access(12'h123);
        check(last_rd == 8'hA0, "R2 code 1 lower", last_rd, 8'hA0);
        check(rom_pwr_on == 1'b1, "R7 power on", rom_pwr_on, 1);
    endtask

    task automatic t_cfg_bits;
        set_cfg(8'h0F);
        check(rom_pwr_on == 1'b0, "R7 power off", rom_pwr_on, 0);
        set_cfg(8'hED);
        access(12'h923);
        check(last_rd == 8'hC2, "R7 bits 7:5 ignored", last_rd, 8'hC2);
        do_write(8'h77, 12'h1C0);
        check(last_rd != 8'h77, "R7 writes disabled", last_rd, 8'h00);
        set_cfg(8'h0E);
        check(rom_pwr_on == 1'b1, "R7 power on again", rom_pwr_on, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mapping();
        t_write_window();
        t_relatch();
        t_rom_drop();
        t_priority();
        t_cfg_disarm();
        t_nostrobe();
        t_we_off_recapture();
        t_cfg_bits();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule